// File: doc/BRIEF.md
# Display Plane Scanout Address Generator

This block keeps the surface start address, the panning offset and the line stride for a single display plane. It turns them into the memory address of each scanout line. Software programs the registers through a one-cycle write strobe with a register select. It can read them back through a combinational read port. The start and stride registers are double-buffered. A write lands in a pending copy. Only a write to the start register arms a transfer, and the armed transfer moves both pending values into the active copies together, on the next rising edge of vertical blank.

At the end of vertical blank, the line address is loaded with the first-pixel address, which is the active start plus the panning offset. Each horizontal-sync rising edge during active lines then moves the address by the active stride. The address moves upward normally and downward when 180-degree rotation is selected. In rotated mode the offset is expected to point at the last pixel of the last line. When tiled memory is selected, two error flags report a pending stride that is not 512-byte aligned or that is larger than 16 KB.

Top module: `plane_scan_addr`

## Requirements
- R1: After reset, lineAddr, updateArmed, both error flags and every register readback are zero.
- R2: Register codes are 0 = start, 1 = offset, 2 = stride and 3 = unused. The stride register keeps write bits 31:6 only, and bits 5:0 always read back as zero.
- R3: A read returns the pending start, the pending stride and the offset. The offset is a single register that takes effect at the next frame start without any arming.
- R4: A stride write on its own does not change the stride used for line stepping, even across a vertical blank.
- R5: A start write sets updateArmed in the next cycle. On the next rising edge of vblank, the pending start and pending stride both become active in the same cycle, and updateArmed clears.
- R6: A falling edge of vblank loads lineAddr with active start plus offset, visible one clock later.
- R7: Each rising edge of hsync while vblank is low adds the active stride to lineAddr one clock later. Hsync edges while vblank is high leave lineAddr unchanged.
- R8: With rotate180 high, each active hsync rising edge subtracts the active stride instead of adding it.
- R9: With tiledMode high, strideAlignErr is set one clock after the pending stride has any of bits 8:6 set.
- R10: With tiledMode high, strideRangeErr is set one clock after the pending stride exceeds 16384. With tiledMode low, both flags read zero.
- R11: Only a rising edge of vblank transfers. A start write made while vblank is already high stays pending, and updateArmed stays set, until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write register code |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read register code |
| rdData | output | 32 | Read data (combinational) |
| tiledMode | input | 1 | Tiled memory layout selected |
| rotate180 | input | 1 | 180-degree rotation selected |
| vblank | input | 1 | Vertical blank level |
| hsync | input | 1 | Horizontal sync level |
| lineAddr | output | 32 | Address of the current scanout line |
| updateArmed | output | 1 | Start written, transfer not yet applied |
| strideAlignErr | output | 1 | Tiled stride not 512-byte aligned |
| strideRangeErr | output | 1 | Tiled stride above 16 KB |

## Verification
Writes take effect at the clock edge inside the write cycle. Reads of the pending registers are combinational, so they are checked one time step after rdSel is set. The error flags are registered from the pending stride, so they are checked one clock after the write has completed. A vblank rise commits at the first edge that sees it. A vblank fall or an hsync rise updates lineAddr at the first edge that sees it. The bench drives every input on the falling clock edge and samples lineAddr at the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_OFFSET = 2'd1,
    SEL_STRIDE = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic loadOffset;
    logic loadStride;
    logic commit;
    logic frameStart;
    logic lineStep;
  } scan_strobe_t;
endpackage

// File: rtl/scan_addr_ctrl.sv
module scan_addr_ctrl
  import scan_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic         vblank,
  input  logic         hsync,
  output scan_strobe_t strb,
  output logic         updateArmed
);
  logic vblankQ, hsyncQ, armed;
  logic vbRise, vbFall, hsRise;

  assign vbRise = vblank & ~vblankQ;
  assign vbFall = ~vblank & vblankQ;
  assign hsRise = hsync & ~hsyncQ;

  always_comb begin
    strb.loadStart  = wrEn && (wrSel == SEL_START);
    strb.loadOffset = wrEn && (wrSel == SEL_OFFSET);
    strb.loadStride = wrEn && (wrSel == SEL_STRIDE);
    strb.commit     = vbRise && armed;
    strb.frameStart = vbFall;
    strb.lineStep   = hsRise && !vblank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vblankQ <= 1'b0;
      hsyncQ  <= 1'b0;
      armed   <= 1'b0;
    end else begin
      vblankQ <= vblank;
      hsyncQ  <= hsync;
      // a start write in the commit cycle keeps the request alive
      if (strb.loadStart)   armed <= 1'b1;
      else if (strb.commit) armed <= 1'b0;
    end
  end

  assign updateArmed = armed;
endmodule

// File: rtl/scan_addr_dp.sv
module scan_addr_dp
  import scan_addr_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int STRIDE_LSB     = 6,
  parameter int TILE_ALIGN_LOG = 9,
  parameter int TILE_MAX       = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_strobe_t      strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  input  logic              tiledMode,
  input  logic              rotate180,
  output logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              alignErr,
  output logic              rangeErr
);
  localparam logic [ADDR_W-1:0] STRIDE_MASK = {{(ADDR_W-STRIDE_LSB){1'b1}}, {STRIDE_LSB{1'b0}}};
  localparam int                TILE_BITS   = TILE_ALIGN_LOG - STRIDE_LSB;

  logic [ADDR_W-1:0] pendStart, pendStride, actStart, actStride, offsetReg;
  logic [ADDR_W-1:0] firstAddr, nextLine;

  assign firstAddr = actStart + offsetReg;
  assign nextLine  = rotate180 ? (lineAddr - actStride) : (lineAddr + actStride);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendStart  <= '0;
      pendStride <= '0;
      actStart   <= '0;
      actStride  <= '0;
      offsetReg  <= '0;
      lineAddr   <= '0;
      alignErr   <= 1'b0;
      rangeErr   <= 1'b0;
    end else begin
      if (strb.loadStart)  pendStart  <= wrData;
      if (strb.loadStride) pendStride <= wrData & STRIDE_MASK;
      if (strb.loadOffset) offsetReg  <= wrData;
      if (strb.commit) begin
        actStart  <= pendStart;
        actStride <= pendStride;
      end
      if (strb.frameStart)    lineAddr <= firstAddr;
      else if (strb.lineStep) lineAddr <= nextLine;
      alignErr <= tiledMode && (|pendStride[STRIDE_LSB +: TILE_BITS]);
      rangeErr <= tiledMode && (pendStride > ADDR_W'(TILE_MAX));
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rdSel))
      SEL_START:  rdData = pendStart;
      SEL_OFFSET: rdData = offsetReg;
      SEL_STRIDE: rdData = pendStride;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/plane_scan_addr.sv
module plane_scan_addr
  import scan_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic              tiledMode,
  input  logic              rotate180,
  input  logic              vblank,
  input  logic              hsync,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              updateArmed,
  output logic              strideAlignErr,
  output logic              strideRangeErr
);
  scan_strobe_t strb;

  scan_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .vblank(vblank), .hsync(hsync), .strb(strb), .updateArmed(updateArmed)
  );

  scan_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .tiledMode(tiledMode), .rotate180(rotate180), .rdData(rdData),
    .lineAddr(lineAddr), .alignErr(strideAlignErr), .rangeErr(strideRangeErr)
  );
endmodule

// File: rtl/scan_addr_checker.sv
module scan_addr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [1:0]        rdSel,
  input logic [ADDR_W-1:0] rdData,
  input logic              tiledMode,
  input logic              vblank,
  input logic              hsync,
  input logic [ADDR_W-1:0] lineAddr,
  input logic              updateArmed,
  input logic              strideAlignErr,
  input logic              strideRangeErr
);
  logic vPrev, hPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPrev <= 1'b0;
      hPrev <= 1'b0;
    end else begin
      vPrev <= vblank;
      hPrev <= hsync;
    end
  end

  assert_stride_low_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 2'd2) |-> (rdData[5:0] == 6'd0));

  assert_start_arms_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0) |=> updateArmed);

  assert_armed_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updateArmed && vblank && !vPrev && !(wrEn && wrSel == 2'd0)) |=> !updateArmed);

  assert_armed_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (updateArmed && !(vblank && !vPrev)) |=> updateArmed);

  assert_line_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(hsync && !hPrev && !vblank) && !(!vblank && vPrev)) |=> $stable(lineAddr));

  assert_no_err_linear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !tiledMode |=> (!strideAlignErr && !strideRangeErr));
endmodule

bind plane_scan_addr scan_addr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .rdSel(rdSel),
  .rdData(rdData), .tiledMode(tiledMode), .vblank(vblank), .hsync(hsync),
  .lineAddr(lineAddr), .updateArmed(updateArmed),
  .strideAlignErr(strideAlignErr), .strideRangeErr(strideRangeErr)
);

// File: tb/sim_plane_scan_addr.sv
module sim_plane_scan_addr;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = 2'd0;
  logic [31:0] rdData;
  logic        tiledMode = 1'b0;
  logic        rotate180 = 1'b0;
  logic        vblank = 1'b0;
  logic        hsync = 1'b0;
  logic [31:0] lineAddr;
  logic        updateArmed, strideAlignErr, strideRangeErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_scan_addr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .tiledMode(tiledMode), .rotate180(rotate180),
    .vblank(vblank), .hsync(hsync), .lineAddr(lineAddr), .updateArmed(updateArmed),
    .strideAlignErr(strideAlignErr), .strideRangeErr(strideRangeErr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(logic [1:0] sel, logic [31:0] exp, string tag);
    rdSel = sel;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic vblankPulse();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    @(negedge clk);
  endtask

  task automatic hsyncPulse();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
  endtask

  task automatic testReset();
    check("R1 lineAddr", lineAddr, 32'h0);
    check("R1 armed", {31'b0, updateArmed}, 32'h0);
    check("R1 errs", {30'b0, strideAlignErr, strideRangeErr}, 32'h0);
    readChk(2'd0, 32'h0, "R1 start read");
    readChk(2'd2, 32'h0, "R1 stride read");
  endtask

  task automatic testProgram();
    writeReg(2'd0, 32'h0000_1000);
    check("R5 armed after start write", {31'b0, updateArmed}, 32'h1);
    writeReg(2'd1, 32'h0000_0040);
    writeReg(2'd2, 32'h0000_023F);
    readChk(2'd2, 32'h0000_0200, "R2 stride low bits dropped");
    readChk(2'd0, 32'h0000_1000, "R3 pending start read");
    readChk(2'd1, 32'h0000_0040, "R3 offset read");
    readChk(2'd3, 32'h0, "R2 unused code reads zero");
  endtask

  task automatic testCommitAndStep();
    vblankPulse();
    check("R5 armed cleared", {31'b0, updateArmed}, 32'h0);
    check("R6 first pixel address", lineAddr, 32'h0000_1040);
    hsyncPulse();
    check("R7 step 1", lineAddr, 32'h0000_1240);
    hsyncPulse();
    check("R7 step 2", lineAddr, 32'h0000_1440);
    @(negedge clk); vblank = 1'b1;
    hsyncPulse();
    check("R7 hsync in blank ignored", lineAddr, 32'h0000_1440);
    @(negedge clk); vblank = 1'b0;
    @(negedge clk);
    check("R6 reload at frame start", lineAddr, 32'h0000_1040);
  endtask

  task automatic testStrideOnly();
    writeReg(2'd2, 32'h0000_0400);
    check("R4 stride write does not arm", {31'b0, updateArmed}, 32'h0);
    vblankPulse();
    hsyncPulse();
    check("R4 old stride kept", lineAddr, 32'h0000_1240);
    writeReg(2'd0, 32'h0000_2000);
    vblankPulse();
    check("R5 new start active", lineAddr, 32'h0000_2040);
    hsyncPulse();
    check("R5 new stride active", lineAddr, 32'h0000_2440);
  endtask

  task automatic testLevelBlank();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk);
    writeReg(2'd0, 32'h0000_3000);
    @(negedge clk); vblank = 1'b0;
    @(negedge clk);
    check("R11 no transfer on held level", lineAddr, 32'h0000_2040);
    check("R11 still armed", {31'b0, updateArmed}, 32'h1);
    vblankPulse();
    check("R11 transfer on next rise", lineAddr, 32'h0000_3040);
  endtask

  task automatic testRotate();
    rotate180 = 1'b1;
    hsyncPulse();
    check("R8 downward step", lineAddr, 32'h0000_2C40);
    hsyncPulse();
    check("R8 second downward step", lineAddr, 32'h0000_2840);
    rotate180 = 1'b0;
    writeReg(2'd1, 32'h0000_0080);
    vblankPulse();
    check("R3 offset applies without arming", lineAddr, 32'h0000_3080);
  endtask

  task automatic testErrors();
    tiledMode = 1'b1;
    writeReg(2'd2, 32'h0000_0400);
    @(negedge clk);
    check("R9 aligned tiled ok", {30'b0, strideAlignErr, strideRangeErr}, 32'h0);
    writeReg(2'd2, 32'h0000_0440);
    @(negedge clk);
    check("R9 misaligned tiled", {30'b0, strideAlignErr, strideRangeErr}, 32'h2);
    writeReg(2'd2, 32'h0000_4000);
    @(negedge clk);
    check("R10 16K limit ok", {30'b0, strideAlignErr, strideRangeErr}, 32'h0);
    writeReg(2'd2, 32'h0000_4200);
    @(negedge clk);
    check("R10 over limit", {30'b0, strideAlignErr, strideRangeErr}, 32'h1);
    tiledMode = 1'b0;
    writeReg(2'd2, 32'h0000_8040);
    @(negedge clk);
    check("R10 linear no errors", {30'b0, strideAlignErr, strideRangeErr}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testCommitAndStep();
    testStrideOnly();
    testLevelBlank();
    testRotate();
    testErrors();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule